// File: doc/BRIEF.md
# Clocked Serial Shift-Clock Generator

This block produces the bit clock that drives the shift register of a synchronous serial port. When the internal source is selected, the bus clock passes through three dividers. The first is a prescaler with four choices. The second is a reloadable 8-bit half-period counter. The third is a toggle flop, which gives a shift clock with exactly 50% duty. When the external source is selected, a serial clock pin is synchronized into the bus domain and drives the shift clock directly.

Alongside the shift clock, the block emits single-cycle rise and fall strobes, so that the shift logic can act on an edge without an edge detector of its own. New divider settings are taken only at the boundary of a half period, so a running clock never shows a shortened phase. An error flag reports an external clock that runs faster than one sixteenth of the bus clock. The flag is raised when two of its edges come fewer than 8 bus clocks apart.

Top module: `shiftclk_gen`

## Requirements
- R1: While `rst_n` is low, `sclk` is 1, `rise_stb` and `fall_stb` are 0, and `ext_fast_err` is 0.
- R2: With `src_ext`=0, `pre_sel` selects the prescale P as follows: 2'b00 gives 1, 2'b01 gives 8, 2'b10 gives 32 and 2'b11 gives 256. The period of `sclk` is 2·P·(N+1) bus clocks, where N is `baud_val`.
- R3: In internal mode, each high phase and each low phase of `sclk` lasts exactly P·(N+1) bus clocks.
- R4: Every value of N from 0x00 to 0xFF is honoured, including N=0 with P=1, which gives a period of 2 bus clocks.
- R5: A change of `pre_sel` or `baud_val` takes effect only at the next edge of `sclk`. The phase already in progress completes with its old length.
- R6: `rise_stb` (`fall_stb`) is high for exactly the one bus clock in which `sclk` first shows 1 (0). The two strobes are never high together.
- R7: With `src_ext`=1, `sclk` equals the value `ext_clk_pin` had 3 bus clocks earlier (two synchronizer stages plus the output register).
- R8: With `src_ext`=1, `pre_sel` and `baud_val` have no effect: while the pin is steady, `sclk` does not change and no strobe fires.
- R9: In external mode, `ext_fast_err` is set when two edges of `sclk` are fewer than 8 bus clocks apart. Edges exactly 8 apart do not set it. Once set, it stays set while `src_ext`=1 and is cleared on the bus clock after `src_ext` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_ext | input | 1 | 1: external pin is the clock source; 0: internal divider chain |
| pre_sel | input | 2 | Prescaler select (1, 8, 32, 256) |
| baud_val | input | 8 | Half-period reload value N |
| ext_clk_pin | input | 1 | Asynchronous external serial clock |
| sclk | output | 1 | Shift clock, idles high |
| rise_stb | output | 1 | One-cycle pulse on a rising shift-clock edge |
| fall_stb | output | 1 | One-cycle pulse on a falling shift-clock edge |
| ext_fast_err | output | 1 | External clock exceeded the rate limit |

## Verification
A wrong count in the prescaler or the half-period counter shows up on the next edge of `sclk`. It appears as a high or low phase whose length differs from P·(N+1), so a single measured phase exposes it within at most one half period. A settings register that is loaded at the wrong moment shortens or stretches the phase in which `baud_val` changed, and this is visible at the very next strobe. In external mode, a missing or extra synchronizer stage moves the strobe by one bus clock within three cycles of a pin edge. A wrong guard count moves the error threshold away from exactly 8 clocks.

// File: rtl/shiftclk_pkg.sv
package shiftclk_pkg;

  localparam int PRE_SEL_W = 2;
  localparam int PRE_CNT_W = 8;

  // Division ratio of the prescaler for a select code.
  function automatic logic [PRE_CNT_W:0] presc_ratio(input logic [PRE_SEL_W-1:0] sel);
    logic [PRE_CNT_W:0] r;
    case (sel)
      2'b00:   r = 9'd1;
      2'b01:   r = 9'd8;
      2'b10:   r = 9'd32;
      default: r = 9'd256;
    endcase
    return r;
  endfunction

  // Terminal count of the prescaler counter for a select code.
  function automatic logic [PRE_CNT_W-1:0] presc_last(input logic [PRE_SEL_W-1:0] sel);
    logic [PRE_CNT_W:0] r;
    r = presc_ratio(sel) - 9'd1;
    return r[PRE_CNT_W-1:0];
  endfunction

  // Full shift-clock period in bus clocks.
  function automatic int unsigned sclk_period(input logic [PRE_SEL_W-1:0] sel, input int unsigned n);
    return 2 * int'(presc_ratio(sel)) * (n + 1);
  endfunction

endpackage

// File: rtl/shiftclk_prescaler.sv
module shiftclk_prescaler
  import shiftclk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold,
  input  logic [PRE_SEL_W-1:0] sel,
  output logic                 tick
);

  logic [PRE_CNT_W-1:0] cnt_q;
  logic [PRE_CNT_W-1:0] last;

  assign last = presc_last(sel);
  assign tick = !hold && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/shiftclk_baudctr.sv
module shiftclk_baudctr #(
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              tick,
  input  logic [BAUD_W-1:0] limit,
  output logic              done
);

  logic [BAUD_W-1:0] cnt_q;

  assign done = !hold && tick && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) cnt_q <= '0;
    else if (done)      cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/shiftclk_extsync.sv
module shiftclk_extsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/shiftclk_guard.sv
module shiftclk_guard #(
  parameter int MIN_GAP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic edge_in,
  output logic err
);

  localparam int GW = (MIN_GAP > 2) ? $clog2(MIN_GAP) : 1;
  localparam logic [GW-1:0] RELOAD = GW'(MIN_GAP - 1);

  logic [GW-1:0] left_q;
  logic          err_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      left_q <= '0;
      err_q  <= 1'b0;
    end else if (edge_in) begin
      err_q  <= err_q | (left_q != '0);
      left_q <= RELOAD;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign err = err_q;

endmodule

// File: rtl/shiftclk_gen.sv
module shiftclk_gen
  import shiftclk_pkg::*;
#(
  parameter int BAUD_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_GAP     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_ext,
  input  logic [1:0]        pre_sel,
  input  logic [BAUD_W-1:0] baud_val,
  input  logic              ext_clk_pin,
  output logic              sclk,
  output logic              rise_stb,
  output logic              fall_stb,
  output logic              ext_fast_err
);

  logic [PRE_SEL_W-1:0] act_sel_q;
  logic [BAUD_W-1:0]    act_baud_q;
  logic                 pre_tick;
  logic                 half_done;
  logic                 ext_sync;
  logic                 ext_edge;
  logic                 sclk_q;
  logic                 sclk_nxt;
  logic                 rise_q;
  logic                 fall_q;

  // Settings are sampled at each half-period boundary, and continuously in external mode.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_sel_q  <= '0;
      act_baud_q <= '0;
    end else if (src_ext || half_done) begin
      act_sel_q  <= pre_sel;
      act_baud_q <= baud_val;
    end
  end

  shiftclk_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (src_ext),
    .sel   (act_sel_q),
    .tick  (pre_tick)
  );

  shiftclk_baudctr #(.BAUD_W(BAUD_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (src_ext),
    .tick  (pre_tick),
    .limit (act_baud_q),
    .done  (half_done)
  );

  shiftclk_extsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ext_clk_pin),
    .dout  (ext_sync)
  );

  assign sclk_nxt = src_ext ? ext_sync : (sclk_q ^ half_done);
  assign ext_edge = src_ext && (ext_sync != sclk_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sclk_q <= sclk_nxt;
      rise_q <= sclk_nxt && !sclk_q;
      fall_q <= !sclk_nxt && sclk_q;
    end
  end

  shiftclk_guard #(.MIN_GAP(MIN_GAP)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (src_ext),
    .edge_in (ext_edge),
    .err     (ext_fast_err)
  );

  assign sclk     = sclk_q;
  assign rise_stb = rise_q;
  assign fall_stb = fall_q;

endmodule

// File: rtl/shiftclk_gen_chk.sv
module shiftclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic src_ext,
  input logic ext_clk_pin,
  input logic sclk,
  input logic rise_stb,
  input logic fall_stb,
  input logic ext_fast_err,
  input logic half_done
);

  logic [2:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)           age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 1'b1;
  end

  assert_idle_high_R1: assert property (@(posedge clk)
    !rst_n |=> (sclk && !rise_stb && !fall_stb && !ext_fast_err));

  assert_rise_marks_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb == (sclk && !$past(sclk)));

  assert_fall_marks_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb == (!sclk && $past(sclk)));

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb}));

  assert_internal_edge_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(src_ext) && (sclk != $past(sclk))) |-> $past(half_done));

  assert_ext_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd4 && $past(src_ext)) |-> (sclk == $past(ext_clk_pin, 3)));

  assert_err_only_external_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fast_err |-> $past(src_ext));

endmodule

bind shiftclk_gen shiftclk_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_ext      (src_ext),
  .ext_clk_pin  (ext_clk_pin),
  .sclk         (sclk),
  .rise_stb     (rise_stb),
  .fall_stb     (fall_stb),
  .ext_fast_err (ext_fast_err),
  .half_done    (half_done)
);

// File: tb/tb_shiftclk_gen.sv
module tb_shiftclk_gen;

  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_ext = 1'b0;
  logic [1:0] pre_sel = 2'b00;
  logic [7:0] baud_val = 8'd0;
  logic       ext_clk_pin = 1'b1;
  logic       sclk, rise_stb, fall_stb, ext_fast_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  shiftclk_gen dut (
    .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .pre_sel(pre_sel),
    .baud_val(baud_val), .ext_clk_pin(ext_clk_pin), .sclk(sclk),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .ext_fast_err(ext_fast_err)
  );

  // {pre_sel, baud, expected period}; period = 2 * P * (N+1)
  localparam logic [25:0] VEC [8] = '{
    {2'd0, 8'd0,   16'd2},
    {2'd0, 8'd5,   16'd12},
    {2'd1, 8'd0,   16'd16},
    {2'd1, 8'd3,   16'd64},
    {2'd2, 8'd1,   16'd128},
    {2'd3, 8'd0,   16'd512},
    {2'd0, 8'd255, 16'd512},
    {2'd2, 8'd255, 16'd16384}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_to(input bit want_rise, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(want_rise ? rise_stb : fall_stb));
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!rise_stb);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int hi, per, lo;
    bit quiet;
    // R1: reset state
    repeat (4) @(negedge clk);
    check(sclk && !rise_stb && !fall_stb && !ext_fast_err, "R1 reset idle",
          {sclk, rise_stb, fall_stb, ext_fast_err}, 4'b1000);
    rst_n = 1'b1;

    // R2 R3 R4: table walk
    for (int i = 0; i < 8; i++) begin
      pre_sel  = VEC[i][25:24];
      baud_val = VEC[i][23:16];
      wait_rise();
      wait_rise();
      count_to(1'b0, hi);
      count_to(1'b1, lo);
      per = hi + lo;
      check(per == int'(VEC[i][15:0]), "R2 period", per, int'(VEC[i][15:0]));
      check(hi == lo, "R3 duty high vs low", hi, lo);
      if (VEC[i][23:16] == 8'd0 || VEC[i][23:16] == 8'd255)
        check(per == int'(VEC[i][15:0]), "R4 baud range end", per, int'(VEC[i][15:0]));
    end

    // R5: mid-phase change keeps the running phase
    pre_sel = 2'b00; baud_val = 8'd9;
    wait_rise(); wait_rise();
    hi = 0;
    repeat (3) begin @(negedge clk); hi++; end
    baud_val = 8'd2;
    do begin @(negedge clk); hi++; end while (!fall_stb);
    check(hi == 10, "R5 running phase kept", hi, 10);
    count_to(1'b1, lo);
    check(lo == 3, "R5 new value next phase", lo, 3);

    // R6: strobes one cycle wide
    @(negedge clk);
    check(!rise_stb && sclk, "R6 rise strobe one cycle", rise_stb, 0);

    // switch to external, pin idle high
    src_ext = 1'b1; ext_clk_pin = 1'b1;
    repeat (20) @(negedge clk);

    // R8: settings ignored while pin steady
    quiet = 1'b1;
    for (int k = 0; k < 40; k++) begin
      baud_val = 8'(k * 7); pre_sel = 2'(k);
      @(negedge clk);
      if (!sclk || rise_stb || fall_stb) quiet = 1'b0;
    end
    check(quiet, "R8 external ignores divider", quiet, 1);

    // R9: edges 8 apart do not set error
    for (int k = 0; k < 6; k++) begin
      ext_clk_pin = ~ext_clk_pin;
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check(!ext_fast_err, "R9 spacing 8 allowed", ext_fast_err, 0);

    // R7: three-cycle latency and strobe placement
    ext_clk_pin = 1'b0;
    @(negedge clk);
    check(sclk, "R7 not yet after 1", sclk, 1);
    @(negedge clk);
    check(sclk, "R7 not yet after 2", sclk, 1);
    @(negedge clk);
    check(!sclk && fall_stb, "R7 follows after 3", {sclk, fall_stb}, 2'b01);
    @(negedge clk);
    check(!fall_stb, "R6 fall strobe one cycle", fall_stb, 0);
    repeat (10) @(negedge clk);

    // R9: edges 4 apart set error, sticky
    ext_clk_pin = 1'b1;
    repeat (4) @(negedge clk);
    ext_clk_pin = 1'b0;
    repeat (6) @(negedge clk);
    check(ext_fast_err, "R9 fast edges flagged", ext_fast_err, 1);
    repeat (20) @(negedge clk);
    check(ext_fast_err, "R9 flag sticky", ext_fast_err, 1);
    src_ext = 1'b0;
    @(negedge clk);
    check(!ext_fast_err, "R9 cleared on internal", ext_fast_err, 0);

    // R2 after returning to internal
    pre_sel = 2'b01; baud_val = 8'd1;
    wait_rise(); wait_rise();
    count_to(1'b1, per);
    check(per == 32, "R2 period after mode return", per, 32);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule